// File: doc/BRIEF.md
# Channel Fault Retry Sequencer

This block sits beside one output of a switching regulator and decides, from digital protection flags, when that output may switch. The flags come from analog sensing and comparators that lie outside the block: a peak-current-limit flag, a short-circuit flag, an over-temperature flag, and a flag that reports the die has cooled through its hysteresis band. A one-microsecond tick serves as the timebase. The block drives the channel enable, shows when cycle-by-cycle limiting is active, asks the converter for a soft-start ramp, and holds a fault flag for the power-good logic.

Each fault type is handled in its own way. A current limit is tolerated for a bounded number of ticks. If it clears in time, regulation goes on. If it does not, the channel is switched off. A short circuit switches the channel off on the next clock edge. Over-temperature switches the channel off and then waits for the cooled flag before any timing starts. Every shutdown ends with a fixed retry wait and a fresh soft start. The fault flag stays set until a retry has ramped back into regulation.

Top module: `chan_fault_seq`

## Requirements
- R1: While `rst` or `disable_i` is high, the block goes to idle on the next edge: `chan_en_o`, `limit_act_o`, `ss_req_o` and `fault_o` are all 0 and both timers are cleared.
- R2: On the first edge with `disable_i` low, an idle block enters soft start (`chan_en_o`=1, `ss_req_o`=1). It stays there until `ss_done_i` is high at an edge, and then enters regulation (`chan_en_o`=1, `ss_req_o`=0).
- R3: In regulation, `oc_lim_i` high at an edge enters limiting (`chan_en_o`=1, `limit_act_o`=1). The limit timer counts only the edges at which `tick_i` is high.
- R4: If `oc_lim_i` is low at an edge while limiting, and no higher fault is present, the block returns to regulation with `fault_o` still 0. The limit timer starts from zero the next time limiting begins.
- R5: At the LIM_TICKS-th ticked edge spent limiting with `oc_lim_i` still high, the channel switches off (`chan_en_o`=0, `limit_act_o`=0) and `fault_o` becomes 1.
- R6: `short_i` high at an edge during soft start, regulation or limiting switches the channel off and sets `fault_o` on that edge. No timer is involved.
- R7: After a current-type shutdown the channel stays off for RETRY_TICKS ticked edges. On the last of these it re-enters soft start with `fault_o` still 1.
- R8: `hot_i` high at an edge during soft start, regulation or limiting switches the channel off and sets `fault_o`. The retry timer does not run until `cool_i` is seen high at an edge. The RETRY_TICKS wait and the soft start then follow.
- R9: `fault_o` clears only on the edge where soft start reaches regulation (`ss_done_i` high), or through R1.
- R10: When several faults are present together, over-temperature wins over short circuit, and short circuit wins over current limit. `oc_lim_i` is ignored during soft start. All fault inputs are ignored while the channel is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disable_i | input | 1 | Global disable; forces idle |
| tick_i | input | 1 | One-cycle timebase strobe (1 µs) |
| oc_lim_i | input | 1 | Peak current at the limit threshold |
| short_i | input | 1 | Current at the short-circuit threshold |
| hot_i | input | 1 | Die temperature above the shutdown threshold |
| cool_i | input | 1 | Die temperature back below the hysteresis point |
| ss_done_i | input | 1 | Soft-start ramp has reached regulation |
| chan_en_o | output | 1 | Channel switching enable |
| limit_act_o | output | 1 | Cycle-by-cycle limiting is active |
| ss_req_o | output | 1 | Soft-start ramp request |
| fault_o | output | 1 | Latched fault for power-good logic |

## Verification
The embedded properties watch, on every cycle, the rules that need only one edge to see. A disable empties all outputs. A short or over-temperature while enabled leaves the channel off with the fault set. Limiting that ends cleanly returns to regulation. The fault flag falls only at a completed soft start or a disable. The timer counts never exceed their limits. The length of the limit window, the exact retry wait, the thermal hold that ignores ticks, and the priority between simultaneous faults depend on counted histories. Only the bench's scenarios show them, with small timer parameters.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_LIMIT = 3'd3,
        ST_HOT   = 3'd4,
        ST_WAIT  = 3'd5
    } cfs_state_e;

    typedef struct packed {
        logic hot;
        logic shrt;
        logic ocl;
    } cfs_flags_t;

    typedef struct packed {
        logic en;
        logic lim;
        logic ss;
        logic flt;
    } cfs_outs_t;

    function automatic logic cfs_is_on(input cfs_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN) || (s == ST_LIMIT);
    endfunction

    function automatic logic cfs_is_off_fault(input cfs_state_e s);
        return (s == ST_HOT) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/cfs_tick_timer.sv
module cfs_tick_timer #(
    parameter int unsigned TICKS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= done_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R5 R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
    import cfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dis_i,
    input  cfs_flags_t flg_i,
    input  logic       cool_i,
    input  logic       ss_done_i,
    input  logic       lim_done_i,
    input  logic       ret_done_i,
    output logic       lim_run_o,
    output logic       ret_run_o,
    output cfs_outs_t  outs_o
);
    cfs_state_e st_q, st_d;
    logic       flt_q, flt_d;

    always_comb begin
        st_d = st_q;
        if (dis_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_SOFT;
                ST_SOFT: begin
                    if (flg_i.hot)       st_d = ST_HOT;
                    else if (flg_i.shrt) st_d = ST_WAIT;
                    else if (ss_done_i)  st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (flg_i.hot)       st_d = ST_HOT;
                    else if (flg_i.shrt) st_d = ST_WAIT;
                    else if (flg_i.ocl)  st_d = ST_LIMIT;
                end
                ST_LIMIT: begin
                    if (flg_i.hot)       st_d = ST_HOT;
                    else if (flg_i.shrt) st_d = ST_WAIT;
                    else if (!flg_i.ocl) st_d = ST_RUN;
                    else if (lim_done_i) st_d = ST_WAIT;
                end
                ST_HOT:   if (cool_i)     st_d = ST_WAIT;
                ST_WAIT:  if (ret_done_i) st_d = ST_SOFT;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flt_d = flt_q;
        if (st_d == ST_IDLE)
            flt_d = 1'b0;
        else if (cfs_is_off_fault(st_d))
            flt_d = 1'b1;
        else if (st_q == ST_SOFT && st_d == ST_RUN)
            flt_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            flt_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            flt_q <= flt_d;
        end
    end

    assign lim_run_o  = (st_q == ST_LIMIT);
    assign ret_run_o  = (st_q == ST_WAIT);
    assign outs_o.en  = cfs_is_on(st_q);
    assign outs_o.lim = (st_q == ST_LIMIT);
    assign outs_o.ss  = (st_q == ST_SOFT);
    assign outs_o.flt = flt_q;

    // R1
    dis_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> !outs_o.en && !outs_o.ss && !outs_o.flt);

    // R6
    short_off_chk: assert property (@(posedge clk) disable iff (rst)
        (outs_o.en && flg_i.shrt && !dis_i) |=> !outs_o.en && outs_o.flt);

    // R8
    hot_off_chk: assert property (@(posedge clk) disable iff (rst)
        (outs_o.en && flg_i.hot && !dis_i) |=> !outs_o.en && outs_o.flt);

    // R4
    lim_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (outs_o.lim && !flg_i.ocl && !flg_i.shrt && !flg_i.hot && !dis_i)
        |=> outs_o.en && !outs_o.lim && !outs_o.flt);

    // R9
    fault_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outs_o.flt) |-> $past(dis_i || (outs_o.ss && ss_done_i)));

    // R2
    ss_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs_o.ss) |-> $past(!outs_o.en));

endmodule

// File: rtl/chan_fault_seq.sv
module chan_fault_seq
    import cfs_pkg::*;
#(
    parameter int unsigned LIM_TICKS   = 10000,
    parameter int unsigned RETRY_TICKS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic disable_i,
    input  logic tick_i,
    input  logic oc_lim_i,
    input  logic short_i,
    input  logic hot_i,
    input  logic cool_i,
    input  logic ss_done_i,
    output logic chan_en_o,
    output logic limit_act_o,
    output logic ss_req_o,
    output logic fault_o
);
    cfs_flags_t flags;
    cfs_outs_t  outs;
    logic       lim_run, ret_run, lim_done, ret_done;

    assign flags = '{hot: hot_i, shrt: short_i, ocl: oc_lim_i};

    cfs_tick_timer #(.TICKS(LIM_TICKS)) u_lim_tmr (
        .clk    (clk),
        .rst    (rst),
        .run_i  (lim_run),
        .tick_i (tick_i),
        .done_o (lim_done)
    );

    cfs_tick_timer #(.TICKS(RETRY_TICKS)) u_ret_tmr (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ret_run),
        .tick_i (tick_i),
        .done_o (ret_done)
    );

    cfs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dis_i      (disable_i),
        .flg_i      (flags),
        .cool_i     (cool_i),
        .ss_done_i  (ss_done_i),
        .lim_done_i (lim_done),
        .ret_done_i (ret_done),
        .lim_run_o  (lim_run),
        .ret_run_o  (ret_run),
        .outs_o     (outs)
    );

    assign chan_en_o   = outs.en;
    assign limit_act_o = outs.lim;
    assign ss_req_o    = outs.ss;
    assign fault_o     = outs.flt;

endmodule

// File: tb/chan_fault_seq_tb.sv
module chan_fault_seq_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 53;

    logic clk = 1'b0;
    logic rst, dis, tick, ocl, shrt, hot, cool, ssd;
    logic en, lim, ssq, flt;
    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    chan_fault_seq #(.LIM_TICKS(3), .RETRY_TICKS(4)) u_dut (
        .clk(clk), .rst(rst), .disable_i(dis), .tick_i(tick),
        .oc_lim_i(ocl), .short_i(shrt), .hot_i(hot), .cool_i(cool),
        .ss_done_i(ssd), .chan_en_o(en), .limit_act_o(lim),
        .ss_req_o(ssq), .fault_o(flt)
    );

    // {req, dis tick ocl short hot cool ssdone, en lim ss fault}
    localparam logic [14:0] VEC [NV] = '{
        {4'd1,  7'b1000000, 4'b0000},  // R1 disabled idle
        {4'd2,  7'b0100000, 4'b1010},  // R2 soft start
        {4'd2,  7'b0000001, 4'b1000},  // R2 regulation
        {4'd3,  7'b0110000, 4'b1100},  // R3 limiting
        {4'd3,  7'b0110000, 4'b1100},  // R3 tick 1
        {4'd4,  7'b0100000, 4'b1000},  // R4 recovers, no fault
        {4'd4,  7'b0010000, 4'b1100},  // R4 fresh window
        {4'd3,  7'b0110000, 4'b1100},  // R3
        {4'd3,  7'b0010000, 4'b1100},  // R3 no tick, no count
        {4'd3,  7'b0110000, 4'b1100},  // R3
        {4'd5,  7'b0110000, 4'b0001},  // R5 third tick expires
        {4'd7,  7'b0100000, 4'b0001},  // R7 retry wait
        {4'd7,  7'b0100000, 4'b0001},
        {4'd7,  7'b0100000, 4'b0001},
        {4'd7,  7'b0100000, 4'b1011},  // R7 fourth tick restarts
        {4'd9,  7'b0000001, 4'b1000},  // R9 fault clears
        {4'd6,  7'b0001000, 4'b0001},  // R6 short off at once
        {4'd7,  7'b0100000, 4'b0001},
        {4'd7,  7'b0100000, 4'b0001},
        {4'd7,  7'b0100000, 4'b0001},
        {4'd7,  7'b0100000, 4'b1011},  // R7
        {4'd9,  7'b0000000, 4'b1011},  // R9 held during ramp
        {4'd9,  7'b0000001, 4'b1000},  // R9
        {4'd8,  7'b0000100, 4'b0001},  // R8 thermal off
        {4'd8,  7'b0100100, 4'b0001},  // R8 ticks ignored while hot
        {4'd8,  7'b0100000, 4'b0001},
        {4'd8,  7'b0000010, 4'b0001},  // R8 cooled, wait begins
        {4'd8,  7'b0100000, 4'b0001},
        {4'd8,  7'b0100000, 4'b0001},
        {4'd8,  7'b0100000, 4'b0001},
        {4'd8,  7'b0100000, 4'b1011},  // R8 retry soft start
        {4'd9,  7'b0000001, 4'b1000},
        {4'd3,  7'b0010000, 4'b1100},
        {4'd10, 7'b0011000, 4'b0001},  // R10 short over limit
        {4'd1,  7'b1000000, 4'b0000},  // R1 disable clears fault
        {4'd2,  7'b0010000, 4'b1010},
        {4'd10, 7'b0010000, 4'b1010},  // R10 ocl ignored in soft start
        {4'd2,  7'b0000001, 4'b1000},
        {4'd3,  7'b0010000, 4'b1100},
        {4'd10, 7'b0010100, 4'b0001},  // R10 thermal over limit
        {4'd8,  7'b0011100, 4'b0001},  // R8 held hot
        {4'd1,  7'b1000000, 4'b0000},
        {4'd2,  7'b0100000, 4'b1010},
        {4'd2,  7'b0000001, 4'b1000},
        {4'd10, 7'b0001100, 4'b0001},  // R10 thermal over short
        {4'd10, 7'b0100000, 4'b0001},  // R10 ticks: still hot hold
        {4'd10, 7'b0100000, 4'b0001},
        {4'd10, 7'b0100000, 4'b0001},
        {4'd10, 7'b0100000, 4'b0001},
        {4'd8,  7'b0000010, 4'b0001},
        {4'd7,  7'b0100000, 4'b0001},
        {4'd1,  7'b1100000, 4'b0000},  // R1 disable during wait
        {4'd2,  7'b0000000, 4'b1010}   // R2
    };

    task automatic check(input int req, input logic [3:0] exp);
        logic [3:0] got;
        got = {en, lim, ssq, flt};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got en/lim/ss/flt=%b expected %b", req, got, exp);
        end
    endtask

    task automatic apply(input logic [6:0] v);
        {dis, tick, ocl, shrt, hot, cool, ssd} = v;
    endtask

    initial begin
        #(CLK_P * 2000);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        apply(7'b0000000);
        repeat (3) @(posedge clk);
        #1 check(1, 4'b0000);  // R1 reset state
        @(negedge clk);
        rst = 1'b0;
        apply(7'b1000000);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i][10:4]);
            @(posedge clk);
            #1 check(int'(VEC[i][14:11]), VEC[i][3:0]);
        end
        // R1: reset while regulating
        @(negedge clk); apply(7'b0000001);
        @(posedge clk); #1 check(2, 4'b1000);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 check(1, 4'b0000);
        // R5: limit window restarts after reset
        @(negedge clk); rst = 1'b0; apply(7'b0000000);
        @(posedge clk); #1 check(2, 4'b1010);
        @(negedge clk); apply(7'b0000001);
        @(posedge clk); #1 check(2, 4'b1000);
        @(negedge clk); apply(7'b0110000);
        @(posedge clk);
        @(posedge clk);
        @(posedge clk); #1 check(5, 4'b1100);
        @(posedge clk); #1 check(5, 4'b0001);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule